// File: doc/BRIEF.md
# Programmable Sound Generator Noise Voice

This block is the noise voice of a square-wave sound generator. A 10-bit down-counter is advanced by a clock-enable tick. It is reloaded from one of three fixed divisors, or from the period last written to the third tone voice. Every expiry of the counter toggles a phase bit. The 16-bit shift register moves one place only on the 0-to-1 edge of that bit, so one shift takes two counter periods.

The noise level is the bit that leaves the register on each shift. In white mode the feedback mixes in an inverted tap. In periodic mode the register simply rotates, which gives a pulse once every 16 shifts. A 4-bit attenuation setting picks one of 16 amplitude levels in 2 dB steps, and the amplitude is forced to zero whenever the noise level is low.

The surrounding sound generator decodes register writes into the three write strobes of this block. It also supplies the tick and sums `amp_o` with the tone voices.

Top module: `psg_noise_gen`

## Requirements
- R1: After reset `noise_o` is 0 and `amp_o` is 0. The shift register holds 0x8000. The counter, phase, rate, white-mode flag and borrowed period are all 0, so the first expiry comes 1024 ticks after reset.
- R2: On each tick the counter decrements modulo 1024. When the decremented value is zero it reloads instead. The reload value is 16 for rate 0, 32 for rate 1 and 64 for rate 2 (`ctrl_rate_i` encoding).
- R3: With rate 3 the reload value is the borrowed period. Each `tone2_we_i` write copies all 10 bits of `tone2_period_i` into it. A period of 1 gives an expiry on every tick.
- R4: Each expiry toggles a phase bit, and the register shifts only when the phase goes from 0 to 1. One shift therefore spans two counter reloads.
- R5: On a shift, `noise_o` takes the register's bit 0 from before the shift. Between shifts `noise_o` holds.
- R6: White mode (`ctrl_white_i`=1): the register shifts right and the new bit 15 is bit 0 XOR NOT bit 3.
- R7: Periodic mode (`ctrl_white_i`=0): the new bit 15 is bit 0. Starting from 0x8000, `noise_o` rises once every 16 shifts, and with rate 0 the rising edges are 512 ticks apart.
- R8: A `ctrl_we_i` write loads the rate and mode and reseeds the register to 0x8000. It does not change the counter or the phase.
- R9: When `noise_o` is 1, `amp_o` is round(8192 x 2^(-v/3)) for attenuation v from 0 to 14 (`vol_i` written via `vol_we_i`), and 0 for v = 15.
- R10: `amp_o` is 0 whenever `noise_o` is 0.
- R11: The attenuation resets to 15, so the voice is silent until it is written.
- R12: Without a tick, the counter, phase, register and `noise_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for the counter |
| ctrl_we_i | input | 1 | Noise control write strobe (also reseeds) |
| ctrl_rate_i | input | 2 | Rate select: 0/1/2 fixed divisors, 3 borrowed period |
| ctrl_white_i | input | 1 | 1 = white noise, 0 = periodic |
| vol_we_i | input | 1 | Attenuation write strobe |
| vol_i | input | 4 | Attenuation step, 15 = silent |
| tone2_we_i | input | 1 | Tone-2 period write strobe |
| tone2_period_i | input | 10 | Full tone-2 period value |
| noise_o | output | 1 | Current noise level |
| amp_o | output | 14 | Attenuated amplitude of the noise level |

## Verification
The bench targets the halved shift rate by timing rising edges of periodic noise at every rate. A design that shifts on every expiry shows half the spacing, and one that ignores the borrowed period runs at the wrong rate in mode 3. It checks that the first pulse after a reseed arrives on the sixteenth shift and not the fifteenth. A design that outputs the new bit 0 instead of the bit shifted out fails that check one shift early. Other targets are a borrowed period of 1, the 1024-tick first expiry after reset, every attenuation level against a computed 2 dB curve, and silence at reset attenuation. A wrong table entry, a missing zero gate or a non-silent reset volume shows up as a bad amplitude.

// File: rtl/psg_noise_pkg.sv
package psg_noise_pkg;

  localparam int AMP_W = 14;

  typedef enum logic [1:0] {
    RATE_DIV16 = 2'd0,
    RATE_DIV32 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TONE2 = 2'd3
  } rate_e;

  // 2 dB per step from full scale 0x2000; step 15 mutes
  function automatic logic [AMP_W-1:0] atten_level(input logic [3:0] step);
    case (step)
      4'd0:    atten_level = AMP_W'(8192);
      4'd1:    atten_level = AMP_W'(6502);
      4'd2:    atten_level = AMP_W'(5161);
      4'd3:    atten_level = AMP_W'(4096);
      4'd4:    atten_level = AMP_W'(3251);
      4'd5:    atten_level = AMP_W'(2580);
      4'd6:    atten_level = AMP_W'(2048);
      4'd7:    atten_level = AMP_W'(1625);
      4'd8:    atten_level = AMP_W'(1290);
      4'd9:    atten_level = AMP_W'(1024);
      4'd10:   atten_level = AMP_W'(813);
      4'd11:   atten_level = AMP_W'(645);
      4'd12:   atten_level = AMP_W'(512);
      4'd13:   atten_level = AMP_W'(406);
      4'd14:   atten_level = AMP_W'(323);
      default: atten_level = '0;
    endcase
  endfunction

endpackage

// File: rtl/psg_noise_div.sv
module psg_noise_div
  import psg_noise_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int RELOAD0 = 16,
  parameter int RELOAD1 = 32,
  parameter int RELOAD2 = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  rate_e            rate_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             shift_o
);

  logic [CNT_W-1:0] cnt_q, cnt_dec, reload;
  logic             phase_q, expire;

  assign cnt_dec = cnt_q - CNT_W'(1);
  assign expire  = tick_i && (cnt_dec == '0);
  assign shift_o = expire && !phase_q;   // phase 0 -> 1

  always_comb begin
    case (rate_i)
      RATE_DIV16: reload = CNT_W'(RELOAD0);
      RATE_DIV32: reload = CNT_W'(RELOAD1);
      RATE_DIV64: reload = CNT_W'(RELOAD2);
      default:    reload = period_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= expire ? reload : cnt_dec;
      if (expire) phase_q <= ~phase_q;
    end
  end

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(phase_q)));

  p_reload_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && rate_i == RATE_DIV32) |=> (cnt_q == CNT_W'(RELOAD1)));

  p_reload_tone2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && rate_i == RATE_TONE2) |=> (cnt_q == $past(period_i)));

  p_every_other_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> (phase_q && !shift_o));

endmodule

// File: rtl/psg_noise_lfsr.sv
module psg_noise_lfsr #(
  parameter int LFSR_W = 16,
  parameter int TAP    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic seed_i,
  input  logic white_i,
  output logic noise_o
);

  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [LFSR_W-1:0] lfsr_q;
  logic              noise_q, fb;

  assign fb      = lfsr_q[0] ^ (white_i & ~lfsr_q[TAP]);
  assign noise_o = noise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q  <= SEED;
      noise_q <= 1'b0;
    end else if (seed_i) begin
      lfsr_q  <= SEED;
    end else if (shift_i) begin
      noise_q <= lfsr_q[0];                    // bit leaving the register
      lfsr_q  <= {fb, lfsr_q[LFSR_W-1:1]};
    end
  end

  p_seed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> (lfsr_q == SEED));

  p_shift_right_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !seed_i) |=> (lfsr_q[LFSR_W-2:0] == $past(lfsr_q[LFSR_W-1:1])));

  p_periodic_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !seed_i && !white_i) |=> (lfsr_q[LFSR_W-1] == $past(lfsr_q[0])));

  p_out_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !seed_i) |=> (noise_q == $past(lfsr_q[0])));

  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(noise_q));

endmodule

// File: rtl/psg_noise_atten.sv
module psg_noise_atten
  import psg_noise_pkg::*;
#(
  parameter int VOL_W = 4
) (
  input  logic             noise_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic [AMP_W-1:0] amp_o
);

  assign amp_o = noise_i ? atten_level(4'(vol_i)) : '0;

endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen
  import psg_noise_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int LFSR_W = 16,
  parameter int VOL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic [1:0]       ctrl_rate_i,
  input  logic             ctrl_white_i,
  input  logic             vol_we_i,
  input  logic [VOL_W-1:0] vol_i,
  input  logic             tone2_we_i,
  input  logic [CNT_W-1:0] tone2_period_i,
  output logic             noise_o,
  output logic [AMP_W-1:0] amp_o
);

  rate_e            rate_q;
  logic             white_q, shift;
  logic [VOL_W-1:0] vol_q;
  logic [CNT_W-1:0] period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= RATE_DIV16;
      white_q  <= 1'b0;
      vol_q    <= '1;
      period_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        rate_q  <= rate_e'(ctrl_rate_i);
        white_q <= ctrl_white_i;
      end
      if (vol_we_i)   vol_q    <= vol_i;
      if (tone2_we_i) period_q <= tone2_period_i;
    end
  end

  psg_noise_div #(.CNT_W(CNT_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rate_i   (rate_q),
    .period_i (period_q),
    .shift_o  (shift)
  );

  psg_noise_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .seed_i  (ctrl_we_i),
    .white_i (white_q),
    .noise_o (noise_o)
  );

  psg_noise_atten #(.VOL_W(VOL_W)) u_atten (
    .noise_i (noise_o),
    .vol_i   (vol_q),
    .amp_o   (amp_o)
  );

  p_amp_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !noise_o |-> (amp_o == '0));

  p_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_q == '1) |-> (amp_o == '0));

  p_noise_needs_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(noise_o));

endmodule

// File: tb/tb_psg_noise_gen.sv
module tb_psg_noise_gen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [1:0]  ctrl_rate_i = '0;
  logic        ctrl_white_i = 1'b0;
  logic        vol_we_i = 1'b0;
  logic [3:0]  vol_i = '0;
  logic        tone2_we_i = 1'b0;
  logic [9:0]  tone2_period_i = '0;
  logic        noise_o;
  logic [13:0] amp_o;

  always #10 clk_i = ~clk_i;

  psg_noise_gen dut (.*);

  int    checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // spec-level reference state
  logic [9:0]  m_cnt = '0, m_per = '0;
  logic        m_ph = 1'b0, m_noise = 1'b0, m_white = 1'b0;
  logic [15:0] m_lfsr = 16'h8000;
  logic [3:0]  m_vol = 4'hf;
  logic [1:0]  m_rate = '0;

  function automatic int exp_level(input int n);
    if (n == 15) return 0;
    return $rtoi(8192.0 * (2.0 ** (-n / 3.0)) + 0.5);
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    logic [9:0] c;
    tick_i = t;
    @(posedge clk_i);
    @(negedge clk_i);
    if (t) begin
      c = m_cnt - 10'd1;
      if (c != 0) m_cnt = c;
      else begin
        case (m_rate)
          2'd0: m_cnt = 10'd16;
          2'd1: m_cnt = 10'd32;
          2'd2: m_cnt = 10'd64;
          default: m_cnt = m_per;
        endcase
        m_ph = ~m_ph;
        if (m_ph) begin
          m_noise = m_lfsr[0];
          m_lfsr  = {m_lfsr[0] ^ (m_white & ~m_lfsr[3]), m_lfsr[15:1]};
        end
      end
    end
    if (ctrl_we_i) begin
      m_rate = ctrl_rate_i; m_white = ctrl_white_i; m_lfsr = 16'h8000;
    end
    if (vol_we_i)   m_vol = vol_i;
    if (tone2_we_i) m_per = tone2_period_i;
    tick_i = 0; ctrl_we_i = 0; vol_we_i = 0; tone2_we_i = 0;
    chk({tag, " noise"}, int'(noise_o), int'(m_noise));
    chk({tag, " amp"}, int'(amp_o), m_noise ? exp_level(int'(m_vol)) : 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic wr_ctrl(input logic [1:0] r, input logic w);
    ctrl_we_i = 1; ctrl_rate_i = r; ctrl_white_i = w; cyc(1'b0);
  endtask

  task automatic wr_vol(input logic [3:0] v);
    vol_we_i = 1; vol_i = v; cyc(1'b0);
  endtask

  task automatic wr_per(input logic [9:0] p);
    tone2_we_i = 1; tone2_period_i = p; cyc(1'b0);
  endtask

  task automatic run_to_rise(input int limit, output int n);
    logic prev;
    n = 0;
    prev = noise_o;
    while (n < limit) begin
      cyc(1'b1);
      n++;
      if (!prev && noise_o) break;
      prev = noise_o;
    end
  endtask

  task automatic t_reset();
    tag = "R1";
    chk("R1 reset noise", int'(noise_o), 0);
    chk("R1 reset amp", int'(amp_o), 0);
    run(1100);   // first expiry at tick 1024 is covered by the model
  endtask

  task automatic t_periodic();
    int n;
    tag = "R7";
    wr_ctrl(2'd0, 1'b0);
    run_to_rise(2000, n);
    chk("R11 silent at reset volume", int'(amp_o), 0);
    run_to_rise(2000, n);
    chk("R4 R7 rise spacing rate0", n, 512);
  endtask

  task automatic t_rates();
    int n;
    tag = "R2";
    wr_ctrl(2'd1, 1'b0);
    run_to_rise(4000, n);
    run_to_rise(4000, n);
    chk("R2 rise spacing rate1", n, 1024);
    wr_ctrl(2'd2, 1'b0);
    run_to_rise(8000, n);
    run_to_rise(8000, n);
    chk("R2 rise spacing rate2", n, 2048);
  endtask

  task automatic t_tone2();
    int n;
    tag = "R3";
    wr_per(10'd3);
    wr_ctrl(2'd3, 1'b0);
    run_to_rise(4000, n);
    run_to_rise(4000, n);
    chk("R3 rise spacing period3", n, 96);
    wr_per(10'd1);
    run_to_rise(4000, n);
    run_to_rise(4000, n);
    chk("R3 rise spacing period1", n, 32);
  endtask

  task automatic t_reseed();
    int n;
    tag = "R8";
    wr_ctrl(2'd0, 1'b0);
    run(200);
    wr_ctrl(2'd0, 1'b0);
    run_to_rise(2000, n);
    // first pulse on the 16th shift: after 15 full shifts, within a 16th
    chk("R5 R8 first pulse after reseed", int'(n > 480 && n <= 512), 1);
  endtask

  task automatic t_white();
    int n;
    tag = "R6";
    wr_ctrl(2'd0, 1'b1);
    run(600);
    tag = "R9";
    for (int v = 0; v < 16; v++) begin
      wr_vol(4'(v));
      run_to_rise(3000, n);
      chk($sformatf("R9 amp step %0d", v), int'(amp_o), exp_level(v));
      while (noise_o && n < 3000) begin cyc(1'b1); n++; end
      chk("R10 amp zero on low", int'(amp_o), 0);
    end
  endtask

  task automatic t_hold();
    logic n0;
    logic [13:0] a0;
    tag = "R12";
    wr_vol(4'd2);
    run(37);
    n0 = noise_o; a0 = amp_o;
    for (int i = 0; i < 300; i++) cyc(1'b0);
    chk("R12 noise held", int'(noise_o), int'(n0));
    chk("R12 amp held", int'(amp_o), int'(a0));
    run(700);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_periodic();
    t_rates();
    t_tone2();
    t_reseed();
    t_white();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule